// File: doc/BRIEF.md
# Four-State Instruction Scheduler Queue

This block is a fixed-size pool of scheduler slots. Each slot holds one dispatched instruction, identified by a tag, and moves it through four states: waiting, pending, ready and executing. Per-slot inputs from the surrounding pipeline tell the queue two things about each slot's operands. The first is whether every operand read latency is now known. The second is whether all register operands are available and all memory dependencies are met. On every clock the queue advances a waiting slot to pending, or a pending slot to ready, as these conditions come true.

An external selector watches the ready bitmap and names one slot to issue. That slot then becomes executing. A writeback carrying the slot's tag releases it. Before dispatching, the front end poses an availability query. The query returns a typed stall code, so the front end knows why it must hold back instead of seeing only a single full flag. A dispatch that follows an "available" answer always lands in the lowest-numbered free slot.

Top module: `sq_sched`

## Requirements
- R1: After reset no slot is occupied: all four state bitmaps and all four non-empty flags are 0, and with no query inputs asserted the status code is 0 (available).
- R2: A dispatch fills the lowest-numbered free slot, one cycle later. The new slot enters ready if `disp_ready` is 1. Otherwise it enters pending if `disp_known` is 1, and waiting if neither is 1.
- R3: A waiting slot whose `op_known` bit is 1 becomes pending on the next cycle. It never jumps straight to ready, even if its `op_ready` bit is also 1.
- R4: A pending slot whose `op_ready` bit is 1 becomes ready on the next cycle. This condition is evaluated on every cycle. A pending slot with `op_ready` at 0 stays pending.
- R5: An issue request whose `issue_idx` names a ready slot makes that slot executing on the next cycle. An issue request naming a slot that is not ready has no effect.
- R6: A writeback makes an executing slot whose tag equals `wb_tag` free on the next cycle. A slot with the same tag that is not yet executing is unaffected.
- R7: `q_status` is a 3-bit code: 0 available, 1 load queue full, 2 store queue full, 3 buffers full, 4 dispatch group stall. Precedence, highest first: buffers full (every slot occupied), then load (`q_is_load` and `lsq_load_full`), then store (`q_is_store` and `lsq_store_full`), then `q_group_stall`.
- R8: Each non-empty flag is 1 exactly when its state bitmap has any bit set.
- R9: A dispatch presented while every slot is occupied changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| q_is_load | input | 1 | Queried instruction needs a load queue entry |
| q_is_store | input | 1 | Queried instruction needs a store queue entry |
| lsq_load_full | input | 1 | Load queue has no room |
| lsq_store_full | input | 1 | Store queue has no room |
| q_group_stall | input | 1 | Dispatch group must stall |
| q_status | output | 3 | Availability code (R7) |
| disp_valid | input | 1 | Dispatch request |
| disp_tag | input | TAG_W | Tag of the dispatched instruction |
| disp_known | input | 1 | All operand latencies known at dispatch |
| disp_ready | input | 1 | Operands available and memory dependencies met at dispatch |
| op_known | input | DEPTH | Per-slot: all operand latencies known |
| op_ready | input | DEPTH | Per-slot: operands available and memory dependencies met |
| issue_valid | input | 1 | Issue request from the selector |
| issue_idx | input | IDX_W | Slot to issue |
| wb_valid | input | 1 | Writeback event |
| wb_tag | input | TAG_W | Tag reaching writeback |
| wait_map | output | DEPTH | Slots in the waiting state |
| pend_map | output | DEPTH | Slots in the pending state |
| ready_map | output | DEPTH | Slots in the ready state |
| exec_map | output | DEPTH | Slots in the executing state |
| wait_any | output | 1 | Some slot is waiting |
| pend_any | output | 1 | Some slot is pending |
| ready_any | output | 1 | Some slot is ready |
| exec_any | output | 1 | Some slot is executing |

## Verification
The embedded assertions check the following on every cycle:
- a slot becomes executing only from ready;
- a slot becomes ready only from pending or by a fresh dispatch;
- a writeback hit always frees its slot;
- a full queue always reports code 3;
- at most one slot is granted per dispatch;
- a dispatch into a full queue never adds a slot.

Only the bench scenarios show the rest: the lowest-free placement, the ignored issue to a non-ready slot, the ignored writeback on a same-tag slot that is not executing, and the precedence among the lower stall codes. The bench shows these by comparing all four bitmaps against a behavioural model after every clock.

// File: rtl/sq_pkg.sv
package sq_pkg;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_PEND = 2'd1,
    ST_RDY  = 2'd2,
    ST_EXEC = 2'd3
  } ent_state_t;

  typedef enum logic [2:0] {
    QS_AVAIL    = 3'd0,
    QS_LOAD     = 3'd1,
    QS_STORE    = 3'd2,
    QS_BUF_FULL = 3'd3,
    QS_GROUP    = 3'd4
  } q_status_t;

  // Initial state of a freshly dispatched slot
  function automatic ent_state_t entry_start(input logic known, input logic ready);
    if (ready)      return ST_RDY;
    else if (known) return ST_PEND;
    else            return ST_WAIT;
  endfunction

  // Stall code with its precedence
  function automatic q_status_t pick_status(input logic full, input logic ld_blk,
                                            input logic st_blk, input logic grp);
    if (full)        return QS_BUF_FULL;
    else if (ld_blk) return QS_LOAD;
    else if (st_blk) return QS_STORE;
    else if (grp)    return QS_GROUP;
    else             return QS_AVAIL;
  endfunction

endpackage

// File: rtl/sq_alloc.sv
module sq_alloc #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [DEPTH-1:0] occupied,
  output logic [DEPTH-1:0] grant,
  output logic             full
);
  logic [DEPTH-1:0] free_vec;
  logic [DEPTH-1:0] lowest_free;

  assign free_vec    = ~occupied;
  assign lowest_free = free_vec & (~free_vec + {{(DEPTH-1){1'b0}}, 1'b1});
  assign full        = ~|free_vec;
  assign grant       = req ? lowest_free : '0;

  // R2: at most one slot granted per dispatch
  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R9: nothing granted when full
  p_no_grant_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (grant == '0));
endmodule

// File: rtl/sq_status.sv
module sq_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       full,
  input  logic       is_load,
  input  logic       is_store,
  input  logic       load_full,
  input  logic       store_full,
  input  logic       group_stall,
  output logic [2:0] code
);
  import sq_pkg::*;

  q_status_t st;
  logic      ld_blk;
  logic      sto_blk;

  assign ld_blk  = is_load & load_full;
  assign sto_blk = is_store & store_full;
  assign st      = pick_status(full, ld_blk, sto_blk, group_stall);
  assign code    = st;

  // R7: a full queue outranks every other cause
  p_full_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (code == 3'd3));

  // R7: the code never leaves its legal range
  p_code_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    code <= 3'd4);
endmodule

// File: rtl/sq_entry.sv
module sq_entry #(
  parameter int TAG_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc,
  input  logic [TAG_W-1:0]   d_tag,
  input  logic               d_known,
  input  logic               d_ready,
  input  logic               known,
  input  logic               ready,
  input  logic               issue,
  input  logic               wb_valid,
  input  logic [TAG_W-1:0]   wb_tag,
  output logic               valid,
  output sq_pkg::ent_state_t st
);
  import sq_pkg::*;

  logic [TAG_W-1:0] tag_q;
  logic             wb_hit;
  logic             to_pend;
  logic             to_rdy;
  logic             to_exec;

  assign wb_hit  = valid && (st == ST_EXEC) && wb_valid && (wb_tag == tag_q);
  assign to_pend = valid && (st == ST_WAIT) && known;
  assign to_rdy  = valid && (st == ST_PEND) && ready;
  assign to_exec = valid && (st == ST_RDY)  && issue;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      st    <= ST_WAIT;
      tag_q <= '0;
    end else if (alloc) begin
      valid <= 1'b1;
      st    <= entry_start(d_known, d_ready);
      tag_q <= d_tag;
    end else begin
      if (to_pend) st <= ST_PEND;
      if (to_rdy)  st <= ST_RDY;
      if (to_exec) st <= ST_EXEC;
      if (wb_hit)  valid <= 1'b0;
    end
  end

  // R5: executing is reached only from ready
  p_exec_from_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && st == ST_EXEC && !$past(valid && st == ST_EXEC))
      |-> $past(valid && st == ST_RDY));

  // R4: ready is reached only from pending or by a fresh dispatch
  p_ready_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && st == ST_RDY && !$past(valid && st == ST_RDY))
      |-> ($past(valid && st == ST_PEND) || !$past(valid)));

  // R6: a writeback hit frees the slot
  p_wb_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_hit |=> !valid);
endmodule

// File: rtl/sq_sched.sv
module sq_sched #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 6,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_is_load,
  input  logic             q_is_store,
  input  logic             lsq_load_full,
  input  logic             lsq_store_full,
  input  logic             q_group_stall,
  output logic [2:0]       q_status,
  input  logic             disp_valid,
  input  logic [TAG_W-1:0] disp_tag,
  input  logic             disp_known,
  input  logic             disp_ready,
  input  logic [DEPTH-1:0] op_known,
  input  logic [DEPTH-1:0] op_ready,
  input  logic             issue_valid,
  input  logic [IDX_W-1:0] issue_idx,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  output logic [DEPTH-1:0] wait_map,
  output logic [DEPTH-1:0] pend_map,
  output logic [DEPTH-1:0] ready_map,
  output logic [DEPTH-1:0] exec_map,
  output logic             wait_any,
  output logic             pend_any,
  output logic             ready_any,
  output logic             exec_any
);
  import sq_pkg::*;

  logic [DEPTH-1:0] occupied;
  logic [DEPTH-1:0] grant;
  logic             full;
  ent_state_t       st_q [DEPTH];

  sq_alloc #(.DEPTH(DEPTH)) u_alloc (
    .clk(clk), .rst_n(rst_n), .req(disp_valid),
    .occupied(occupied), .grant(grant), .full(full)
  );

  sq_status u_status (
    .clk(clk), .rst_n(rst_n), .full(full),
    .is_load(q_is_load), .is_store(q_is_store),
    .load_full(lsq_load_full), .store_full(lsq_store_full),
    .group_stall(q_group_stall), .code(q_status)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic issue_here;
    assign issue_here = issue_valid && (issue_idx == IDX_W'(i));

    sq_entry #(.TAG_W(TAG_W)) u_entry (
      .clk(clk), .rst_n(rst_n), .alloc(grant[i]),
      .d_tag(disp_tag), .d_known(disp_known), .d_ready(disp_ready),
      .known(op_known[i]), .ready(op_ready[i]), .issue(issue_here),
      .wb_valid(wb_valid), .wb_tag(wb_tag),
      .valid(occupied[i]), .st(st_q[i])
    );

    assign wait_map[i]  = occupied[i] && (st_q[i] == ST_WAIT);
    assign pend_map[i]  = occupied[i] && (st_q[i] == ST_PEND);
    assign ready_map[i] = occupied[i] && (st_q[i] == ST_RDY);
    assign exec_map[i]  = occupied[i] && (st_q[i] == ST_EXEC);
  end

  assign wait_any  = |wait_map;
  assign pend_any  = |pend_map;
  assign ready_any = |ready_map;
  assign exec_any  = |exec_map;

  // R9: a dispatch into a full queue adds no slot
  p_full_disp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && full) |=> ($countones(occupied) <= $past($countones(occupied))));

  // R8: the four state maps never overlap
  p_maps_disjoint_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(wait_map) + $countones(pend_map) + $countones(ready_map)
     + $countones(exec_map)) == $countones(occupied));
endmodule

// File: tb/sq_sched_tb.sv
module sq_sched_tb;
  localparam int DEPTH = 16;
  localparam int TAG_W = 6;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q_is_load = 0, q_is_store = 0, lsq_load_full = 0, lsq_store_full = 0, q_group_stall = 0;
  logic [2:0] q_status;
  logic disp_valid = 0, disp_known = 0, disp_ready = 0;
  logic [TAG_W-1:0] disp_tag = '0;
  logic [DEPTH-1:0] op_known = '0, op_ready = '0;
  logic issue_valid = 0;
  logic [IDX_W-1:0] issue_idx = '0;
  logic wb_valid = 0;
  logic [TAG_W-1:0] wb_tag = '0;
  logic [DEPTH-1:0] wait_map, pend_map, ready_map, exec_map;
  logic wait_any, pend_any, ready_any, exec_any;

  int checks = 0;
  int errors = 0;
  int m_v [DEPTH];
  int m_s [DEPTH];
  int m_t [DEPTH];

  always #5 clk = ~clk;

  sq_sched #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .q_is_load(q_is_load), .q_is_store(q_is_store),
    .lsq_load_full(lsq_load_full), .lsq_store_full(lsq_store_full),
    .q_group_stall(q_group_stall), .q_status(q_status),
    .disp_valid(disp_valid), .disp_tag(disp_tag),
    .disp_known(disp_known), .disp_ready(disp_ready),
    .op_known(op_known), .op_ready(op_ready),
    .issue_valid(issue_valid), .issue_idx(issue_idx),
    .wb_valid(wb_valid), .wb_tag(wb_tag),
    .wait_map(wait_map), .pend_map(pend_map), .ready_map(ready_map), .exec_map(exec_map),
    .wait_any(wait_any), .pend_any(pend_any), .ready_any(ready_any), .exec_any(exec_any)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DEPTH-1:0] model_map(input int s);
    logic [DEPTH-1:0] m = '0;
    for (int i = 0; i < DEPTH; i++) m[i] = (m_v[i] != 0) && (m_s[i] == s);
    return m;
  endfunction

  function automatic int model_count();
    int n = 0;
    for (int i = 0; i < DEPTH; i++) n += m_v[i];
    return n;
  endfunction

  function automatic int exp_status();
    if (model_count() == DEPTH) return 3;
    if (q_is_load && lsq_load_full) return 1;
    if (q_is_store && lsq_store_full) return 2;
    if (q_group_stall) return 4;
    return 0;
  endfunction

  task automatic model_step();
    int nv [DEPTH];
    int ns [DEPTH];
    for (int i = 0; i < DEPTH; i++) begin
      nv[i] = m_v[i];
      ns[i] = m_s[i];
      if (m_v[i] != 0) begin
        if (m_s[i] == 0 && op_known[i]) ns[i] = 1;
        else if (m_s[i] == 1 && op_ready[i]) ns[i] = 2;
        else if (m_s[i] == 2 && issue_valid && int'(issue_idx) == i) ns[i] = 3;
        else if (m_s[i] == 3 && wb_valid && int'(wb_tag) == m_t[i]) nv[i] = 0;
      end
    end
    if (disp_valid) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (m_v[i] == 0) begin
          nv[i] = 1;
          ns[i] = disp_ready ? 2 : (disp_known ? 1 : 0);
          m_t[i] = int'(disp_tag);
          break;
        end
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      m_v[i] = nv[i];
      m_s[i] = ns[i];
    end
  endtask

  task automatic compare_all();
    chk("R2 R3", "wait_map", wait_map, model_map(0));
    chk("R3 R4", "pend_map", pend_map, model_map(1));
    chk("R4 R5", "ready_map", ready_map, model_map(2));
    chk("R5 R6", "exec_map", exec_map, model_map(3));
    chk("R8", "any flags", {wait_any, pend_any, ready_any, exec_any},
        {|model_map(0), |model_map(1), |model_map(2), |model_map(3)});
    chk("R7", "q_status", q_status, exp_status());
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    disp_valid = 0; issue_valid = 0; wb_valid = 0;
    compare_all();
  endtask

  task automatic dispatch(input int tag, input logic k, input logic r);
    disp_valid = 1; disp_tag = TAG_W'(tag); disp_known = k; disp_ready = r;
    tick();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_s[i] = 0; m_t[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1", "maps after reset", {wait_map, pend_map, ready_map, exec_map}, 0);
    chk("R1", "flags after reset", {wait_any, pend_any, ready_any, exec_any}, 0);
    chk("R1", "status after reset", q_status, 0);

    // R2: three kinds of dispatch into slots 0,1,2
    dispatch(5, 1, 1);
    chk("R2", "slot0 ready", ready_map[0], 1);
    dispatch(6, 1, 0);
    chk("R2", "slot1 pending", pend_map[1], 1);
    dispatch(7, 0, 0);
    chk("R2", "slot2 waiting", wait_map[2], 1);

    // R5: issue to pending slot 1 ignored
    issue_valid = 1; issue_idx = 4'd1;
    tick();
    chk("R5", "issue to non-ready ignored", pend_map[1], 1);

    // R3: slot 2 known and ready goes via pending
    op_known[2] = 1; op_ready[2] = 1;
    tick();
    chk("R3", "waiting does not skip to ready", pend_map[2], 1);
    tick();
    chk("R4", "pending slot2 becomes ready", ready_map[2], 1);
    op_known[2] = 0; op_ready[2] = 0;

    // R4: slot 1 stays pending without ready
    tick();
    chk("R4", "pending holds", pend_map[1], 1);

    // R5: issue slot 0
    issue_valid = 1; issue_idx = 4'd0;
    tick();
    chk("R5", "slot0 executing", exec_map[0], 1);

    // R6: writeback tag 6 while slot1 not executing ignored
    wb_valid = 1; wb_tag = 6'd6;
    tick();
    chk("R6", "non-executing same tag kept", pend_map[1], 1);
    wb_valid = 1; wb_tag = 6'd5;
    tick();
    chk("R6", "slot0 freed", exec_map[0], 0);

    // R2: refill goes to lowest free slot 0
    dispatch(9, 0, 0);
    chk("R2", "lowest free slot reused", wait_map[0], 1);

    // R7: status precedence with space left
    q_is_load = 1; lsq_load_full = 1; q_is_store = 1; lsq_store_full = 1; q_group_stall = 1;
    #1 chk("R7", "load outranks store", q_status, 1);
    lsq_load_full = 0;
    #1 chk("R7", "store outranks group", q_status, 2);
    q_is_store = 0;
    #1 chk("R7", "group stall", q_status, 4);
    q_group_stall = 0; q_is_load = 0; lsq_store_full = 0;
    #1 chk("R7", "available", q_status, 0);

    // fill the queue
    for (int n = 0; n < DEPTH - 3; n++) dispatch(20 + n, n % 2, 0);
    lsq_load_full = 1; q_is_load = 1;
    #1 chk("R7", "buffers full outranks load", q_status, 3);
    q_is_load = 0; lsq_load_full = 0;

    // R9: dispatch into a full queue
    dispatch(50, 1, 1);
    chk("R9", "full dispatch ignored", model_count(), DEPTH);

    // drain some traffic: make all ready and issue a few
    op_known = '1; op_ready = '1;
    tick(); tick();
    op_known = '0; op_ready = '0;
    for (int n = 0; n < 4; n++) begin
      issue_valid = 1; issue_idx = IDX_W'(n * 3);
      tick();
    end
    wb_valid = 1; wb_tag = 6'd20;
    tick();
    tick();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule